// File: doc/BRIEF.md
# Paged Digital I/O Bank with Edge Capture

This block is a 48-line digital I/O controller on an 8-bit register bus. The lines are grouped into six 8-bit ports. Each port has a data register that drives an open-drain style pull-low output. A register read returns the synchronized line level, inverted. Writing a 1 to a port bit pulls the line low. Writing a 0 releases the line, which is how a line is made an input.

The 24 lines of ports 0 to 2 can capture edges. Each line has its own polarity bit and enable bit. A captured edge sets an ID bit, which stays set until software clears it. A pending summary register shows which of those three ports hold a captured edge, and the interrupt output is the OR of that summary.

Three offsets above the page/lock register are banked. The page field of the page/lock register picks whether they reach the polarity, enable or ID registers. Its low bits freeze individual port data registers against writes.

Top module: `dio_paged_bank`

## Requirements
- R1: After reset the page is 0, no port is locked, `pad_pull_low` is all zero, `irq` is 0, and reads of offset 6 and of offsets 8 to 10 return 0.
- R2: A write to offset p (0 to 5) of an unlocked port sets `pad_pull_low[8p+7:8p]` to the written byte on the next clock; a 1 pulls the line low. A read of offset p returns the bitwise inverse of `pad_in[8p+7:8p]` as it was two clock edges earlier.
- R3: A write to offset 7 loads the page from bits 7:6 and the locks from bits 5:0. Bit p set locks port p, and a write to a locked port leaves its output unchanged.
- R4: Offsets 8, 9 and 10 address ports 0, 1 and 2 of the register selected by the page: 1 is polarity, 2 is enable, 3 is ID. On page 0 writes to them have no effect. Polarity and enable are write-only and read back as 0.
- R5: An enabled line whose polarity bit is 1 captures a rising edge, and one whose polarity bit is 0 captures a falling edge, setting its ID bit. The opposite edge sets nothing.
- R6: A line whose enable bit is 0 never sets its ID bit.
- R7: On page 3, writing a 0 to an ID bit clears it and writing a 1 leaves it unchanged. If an edge is captured in the same cycle as a clear, the captured edge wins.
- R8: A read of offset 6 returns in bit i the OR of port i's ID bits (i = 0 to 2), and 0 in bits 7:3.
- R9: `irq` is 1 exactly when any ID bit of ports 0 to 2 is set.
- R10: Activity on lines 24 to 47 never sets a pending bit or `irq`.
- R11: An edge on `pad_in` that arrives before clock edge 1 becomes visible in the ID register, in the summary and on `irq` after clock edge 3 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 48 | Sensed line levels (asynchronous) |
| pad_pull_low | output | 48 | 1 pulls the matching line low |
| irq | output | 1 | Any captured edge on ports 0 to 2 |

## Verification
A wrong ID or enable state shows up in the summary byte and on `irq` after the third clock edge following the line change. That timing gives the bench a fixed cycle at which to look. A wrong page or lock state shows on the first later write, as a port output that changes when it should not, or a banked register that does not change when it should. The bench keeps a model of every register and of the line levels. After every random write or line change, it compares the outputs, `irq` and a read of a random offset against that model.

// File: rtl/dio_pkg.sv
// Shared definitions for the paged digital I/O bank.
// Assumes the register map fits a 4-bit offset and ports are at most 8 bits.
package dio_pkg;
    typedef enum logic [1:0] {
        PG_DATA = 2'd0,
        PG_POL  = 2'd1,
        PG_ENAB = 2'd2,
        PG_ID   = 2'd3
    } page_e;

    localparam int OFS_PEND  = 6;   // pending summary (read-only)
    localparam int OFS_PGLK  = 7;   // page select and port locks (write-only)
    localparam int OFS_PAGED = 8;   // first banked offset
endpackage

// File: rtl/dio_sync2.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module dio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Resample the asynchronous inputs twice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/dio_edge_port.sv
// Edge capture for one interrupt-capable port.
// Compares the synchronized level with its previous value, qualifies by
// per-bit enable and polarity, and holds captures until cleared by a
// write of 0. A capture wins over a clear in the same cycle.
module dio_edge_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] en,
    input  logic         clr_we,
    input  logic [W-1:0] clr_keep,
    output logic [W-1:0] id_q
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] hit;

    // Qualify raw edges by polarity and enable.
    always_comb begin
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        hit  = en & ((pol & rise) | (~pol & fall));
    end

    // Track the previous level and update the capture bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            id_q   <= '0;
        end else begin
            prev_q <= lvl;
            id_q   <= (clr_we ? (id_q & clr_keep) : id_q) | hit;
        end
    end
endmodule

// File: rtl/dio_paged_bank.sv
// Paged 48-line digital I/O bank with edge capture on the low ports.
// Register bus: single-cycle writes, combinational reads. Offsets 0..NUM_PORTS-1
// are port data, OFS_PEND is the summary, OFS_PGLK holds page and locks, and
// OFS_PAGED.. are banked by page. Assumes NUM_PORTS <= PORT_W-2.
module dio_paged_bank
    import dio_pkg::*;
#(
    parameter int PORT_W     = 8,
    parameter int NUM_PORTS  = 6,
    parameter int INTR_PORTS = 3,
    parameter int ADDR_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [PORT_W-1:0]           bus_wdata,
    input  logic                        bus_wr,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_pull_low,
    output logic                        irq
);
    localparam int LINES = NUM_PORTS * PORT_W;

    logic [NUM_PORTS-1:0][PORT_W-1:0]  port_q;
    logic [NUM_PORTS-1:0][PORT_W-1:0]  line_s;
    logic [NUM_PORTS-1:0]              lock_q;
    page_e                             page_q;
    logic [INTR_PORTS-1:0][PORT_W-1:0] pol_q;
    logic [INTR_PORTS-1:0][PORT_W-1:0] en_q;
    logic [INTR_PORTS-1:0][PORT_W-1:0] id_q;
    logic [INTR_PORTS-1:0]             pending;
    logic [INTR_PORTS-1:0]             paged_hit;

    dio_sync2 #(.W(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (line_s)
    );

    // Port data registers, each guarded by its lock bit.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n)
                port_q[p] <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(p) && !lock_q[p])
                port_q[p] <= bus_wdata;
        end
    end

    assign pad_pull_low = port_q;

    // Page select and lock bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= PG_DATA;
            lock_q <= '0;
        end else if (bus_wr && bus_addr == ADDR_W'(OFS_PGLK)) begin
            page_q <= page_e'(bus_wdata[PORT_W-1 -: 2]);
            lock_q <= bus_wdata[NUM_PORTS-1:0];
        end
    end

    // Banked registers and edge capture for the interrupt-capable ports.
    for (genvar i = 0; i < INTR_PORTS; i++) begin : g_intr
        assign paged_hit[i] = bus_addr == ADDR_W'(OFS_PAGED + i);

        // Polarity and enable registers, written only on their page.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pol_q[i] <= '0;
                en_q[i]  <= '0;
            end else if (bus_wr && paged_hit[i]) begin
                if (page_q == PG_POL)  pol_q[i] <= bus_wdata;
                if (page_q == PG_ENAB) en_q[i]  <= bus_wdata;
            end
        end

        dio_edge_port #(.W(PORT_W)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (line_s[i]),
            .pol      (pol_q[i]),
            .en       (en_q[i]),
            .clr_we   (bus_wr && paged_hit[i] && page_q == PG_ID),
            .clr_keep (bus_wdata),
            .id_q     (id_q[i])
        );

        assign pending[i] = |id_q[i];
    end

    assign irq = |pending;

    // Read mux: inverted line level, summary, and ID on page 3.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (bus_addr == ADDR_W'(p)) bus_rdata = ~line_s[p];
        if (bus_addr == ADDR_W'(OFS_PEND)) bus_rdata = PORT_W'(pending);
        for (int i = 0; i < INTR_PORTS; i++)
            if (paged_hit[i] && page_q == PG_ID) bus_rdata = id_q[i];
    end
endmodule

// File: rtl/dio_paged_bank_chk.sv
// Property checker for dio_paged_bank, attached by bind.
// Observes ports and selected internal registers; drives nothing.
module dio_paged_bank_chk #(
    parameter int PORT_W     = 8,
    parameter int NUM_PORTS  = 6,
    parameter int INTR_PORTS = 3,
    parameter int ADDR_W     = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_wr,
    input logic [PORT_W-1:0]            bus_rdata,
    input logic [NUM_PORTS*PORT_W-1:0]  pad_pull_low,
    input logic                         irq,
    input logic [NUM_PORTS-1:0]         lock_q,
    input logic [1:0]                   page_q,
    input logic [INTR_PORTS*PORT_W-1:0] pol_q,
    input logic [INTR_PORTS*PORT_W-1:0] en_q,
    input logic [INTR_PORTS*PORT_W-1:0] id_q
);
    localparam int IW = INTR_PORTS * PORT_W;

    AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_pull_low == '0 && !irq)); // R1

    AST_PAGE0_NO_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && page_q == 2'd0 && bus_addr >= ADDR_W'(8)) |=> ($stable(pol_q) && $stable(en_q))); // R4

    AST_SUMMARY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(6)) |-> (bus_rdata[PORT_W-1:INTR_PORTS] == '0)); // R8

    AST_IRQ_MATCHES_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(6)) |-> (irq == (bus_rdata != '0))); // R9

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lock
        AST_LOCKED_PORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(p) && lock_q[p]) |=> $stable(pad_pull_low)); // R3
    end

    for (genvar b = 0; b < IW; b++) begin : g_en
        AST_CAPTURE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(id_q[b]) |-> $past(en_q[b])); // R6
    end
endmodule

bind dio_paged_bank dio_paged_bank_chk #(
    .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .INTR_PORTS(INTR_PORTS), .ADDR_W(ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .pad_pull_low (pad_pull_low),
    .irq          (irq),
    .lock_q       (lock_q),
    .page_q       (page_q),
    .pol_q        (pol_q),
    .en_q         (en_q),
    .id_q         (id_q)
);

// File: tb/dio_paged_bank_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a register-level model kept in the bench.
module dio_paged_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic [47:0] pad_in = '0;
    logic [47:0] pad_pull_low;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [5:0][7:0] m_port;
    logic [5:0]      m_lock;
    logic [1:0]      m_page;
    logic [2:0][7:0] m_pol, m_en, m_id;
    logic [47:0]     m_pad;

    dio_paged_bank u_dio_paged_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_pull_low(pad_pull_low), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        if (a < 6) return ~m_pad[a*8 +: 8];
        if (a == 6) return {5'd0, |m_id[2], |m_id[1], |m_id[0]};
        if (a >= 8 && a <= 10 && m_page == 2'd3) return m_id[a-8];
        return 8'h00;
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        if (a < 6) begin
            if (!m_lock[a]) m_port[a] = d;
        end else if (a == 7) begin
            m_page = d[7:6];
            m_lock = d[5:0];
        end else if (a >= 8 && a <= 10) begin
            case (m_page)
                2'd1: m_pol[a-8] = d;
                2'd2: m_en[a-8]  = d;
                2'd3: m_id[a-8]  = m_id[a-8] & d;
                default: ;
            endcase
        end
    endtask

    task automatic model_pad(input logic [47:0] nw);
        for (int b = 0; b < 24; b++) begin
            logic r, f;
            r = nw[b] & ~m_pad[b];
            f = ~nw[b] & m_pad[b];
            if (m_en[b/8][b%8] && (m_pol[b/8][b%8] ? r : f)) m_id[b/8][b%8] = 1'b1;
        end
        m_pad = nw;
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic do_write(input int a, input logic [7:0] d);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_pad(input logic [47:0] nw);
        pad_in = nw;
        model_pad(nw);
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        bus_addr = 4'(a);
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [47:0] nw;
        void'($urandom(32'h5EED_0042));
        m_port = '0; m_lock = '0; m_page = '0; m_pol = '0; m_en = '0; m_id = '0; m_pad = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pull_low", pad_pull_low, 0);
        chk("R1 irq", irq, 0);
        rd(6, d); chk("R1 summary", d, 0);
        rd(8, d); chk("R1 banked read", d, 0);

        // R2: port write and inverted readback
        do_write(0, 8'hA5);
        chk("R2 port0 drive", pad_pull_low[7:0], 8'hA5);
        do_write(5, 8'h3C);
        chk("R2 port5 drive", pad_pull_low[47:40], 8'h3C);
        do_pad(48'h0000_0000_0F00);
        rd(1, d); chk("R2 port1 inverted read", d, 8'hF0);

        // R3: lock port 2, write ignored; unlock, write lands
        do_write(7, 8'h04);
        do_write(2, 8'hFF);
        chk("R3 locked port", pad_pull_low[23:16], 8'h00);
        do_write(7, 8'h00);
        do_write(2, 8'h11);
        chk("R3 unlocked port", pad_pull_low[23:16], 8'h11);

        // R4: page 0 banked writes ignored; polarity is write-only
        do_write(8, 8'hFF);
        do_write(9, 8'hFF);
        do_write(7, 8'h40);
        do_write(8, 8'h0F);
        rd(8, d); chk("R4 polarity reads zero", d, 0);
        do_write(7, 8'h80);
        do_write(8, 8'hFF);
        rd(8, d); chk("R4 enable reads zero", d, 0);
        do_write(7, 8'hC0);
        rd(8, d); chk("R4 id on page 3", d, 0);

        // R6: port 1 was never enabled (page-0 write ignored)
        do_pad(48'h0000_0000_F000);
        rd(9, d); chk("R6 disabled port no capture", d, 0);
        chk("R6 irq", irq, 0);

        // R11 and R5: rising edge on line 0 with polarity 1
        pad_in = 48'h0000_0000_F001;
        @(negedge clk); @(negedge clk);
        rd(8, d); chk("R11 not yet after two edges", d, 0);
        chk("R11 irq not yet", irq, 0);
        @(negedge clk);
        rd(8, d); chk("R11 captured after third edge", d, 8'h01);
        chk("R9 irq set", irq, 1);
        rd(6, d); chk("R8 summary port0", d, 8'h01);
        model_pad(48'h0000_0000_F001);
        @(negedge clk);

        // R5: line 4 (polarity 0) ignores rise, captures fall; line 0 fall ignored
        do_pad(48'h0000_0000_F011);
        rd(8, d); chk("R5 rise ignored on falling polarity", d, 8'h01);
        do_pad(48'h0000_0000_F001);
        rd(8, d); chk("R5 falling capture", d, 8'h11);
        do_pad(48'h0000_0000_F000);
        rd(8, d); chk("R5 fall ignored on rising polarity", d, 8'h11);

        // R7: clear with 0, keep with 1
        do_write(8, 8'hEF);
        rd(8, d); chk("R7 selective clear", d, 8'h01);
        // R7: capture on line 1 in the same cycle as a full clear
        pad_in = 48'h0000_0000_F002;
        @(negedge clk); @(negedge clk);
        bus_addr = 4'd8; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        m_id[0] = 8'h02; m_pad = 48'h0000_0000_F002;
        rd(8, d); chk("R7 capture wins over clear", d, 8'h02);
        do_write(8, 8'h00);
        chk("R9 irq clears", irq, 0);

        // R10: upper lines toggle, no interrupt
        do_pad(48'hFFFF_FF00_F002);
        chk("R10 irq after upper rise", irq, 0);
        do_pad(48'h0000_0000_F002);
        rd(6, d); chk("R10 summary after upper fall", d, 0);

        // Random traffic against the model
        for (int it = 0; it < 600; it++) begin
            int a;
            if ($urandom_range(0, 9) < 6) begin
                do_write(int'($urandom_range(0, 15)), 8'($urandom()));
            end else begin
                nw = {16'($urandom()), 32'($urandom())};
                do_pad(nw);
            end
            chk("R2 drive", pad_pull_low, m_port);
            chk("R9 irq", irq, |m_id);
            a = int'($urandom_range(0, 15));
            rd(a, d);
            chk("R5 read", d, exp_read(a));
            @(negedge clk);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule